// File: doc/BRIEF.md
# Interrupt Daisy-Chain Vector Controller

This block arbitrates eight interrupt sources, four from each of two serial channels (A and B), and takes part in a daisy-chained priority scheme. A chain enable input (`iei`) comes from the higher-priority neighbour. A chain enable output (`ieo`) goes to the lower-priority neighbour. When the host runs an acknowledge cycle, the highest-priority device that has a request and a high `iei` drives an 8-bit vector onto a bus that it can release. It also records the winning source in an in-service register. This block keeps one in-service bit for each source, so a higher-priority source can nest above a lower-priority one.

A 5-bit control register holds the following bits:

| Bit | Name | Effect |
|-----|------|--------|
| 4 | status high | Selects where the status code goes in the vector |
| 3 | master enable | Gates all requests |
| 2 | chain cut | Blocks lower-priority devices |
| 1 | vector suppress | Keeps the bus released during acknowledge |
| 0 | status in vector | Puts the status code into the vector on the bus |

An 8-bit base register holds the vector. A status-modified copy of the vector can be read at all times. A release strobe clears the highest in-service bit when the handler finishes.

Top module: `intvec_ctl`

## Requirements
- R1: Reset clears the control register, the base register and all in-service bits. After reset, `bus_oe` is 0, `stat_vec` is 0 and `ieo` follows `iei`. While status high is 0, a pending source places its code in bits 3:1 of `stat_vec`.
- R2: Each pending input is indexed as {channel, source}, with channel A = 1 and channel B = 0. The source codes are: transmit empty 00 (pend bit 0), external change 01 (bit 1), receive available 10 (bit 2), special receive 11 (bit 3). With status high = 0, `stat_vec` is the base vector with bits 3,2,1 replaced by the 3-bit code, bit 3 being the code MSB.
- R3: With status high = 1, the code goes into bits 4,5,6, with bit 4 taking the code MSB and bit 6 the LSB. All other bits come from the base vector.
- R4: When no source is pending, `stat_vec` equals the base vector.
- R5: The sources rank as follows, highest first:
  - channel A special receive
  - channel A receive available
  - channel A transmit empty
  - channel A external change
  - channel B special receive
  - channel B receive available
  - channel B transmit empty
  - channel B external change

  The code shown is that of the highest-ranked pending source.
- R6: An acknowledge is taken when `ack` is high, `iei` is high, master enable is 1, and the top pending source outranks every in-service bit. In that cycle, `bus_oe` is 1 and `bus_out` is `stat_vec` if status in vector is 1, or the base vector otherwise. The winner's in-service bit is set at the clock edge, which drives `ieo` low.
- R7: With vector suppress = 1, `bus_oe` stays 0 during a taken acknowledge, whatever status in vector is. The in-service bit is still set.
- R8: With master enable = 0, pending sources raise no request, `ieo` follows `iei` unless an in-service bit is set, and no in-service bit can be set. In-service bits set earlier stay set after master enable is cleared.
- R9: With chain cut = 1, `ieo` is 0 regardless of `iei`.
- R10: With `iei` low, an acknowledge is not answered and sets no in-service bit.
- R11: A `rst_ius` pulse clears only the highest-ranked in-service bit. A pending source with a lower or equal rank than a set in-service bit raises no request, while a higher-ranked one does.
- R12: `bus_out` is 0 whenever `bus_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hardware reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 5 | Control bits: {status high, master enable, chain cut, vector suppress, status in vector} |
| base_we | input | 1 | Base vector write strobe |
| base_wdata | input | 8 | Base vector value |
| pend_a | input | 4 | Channel A pending sources: [3] special, [2] receive, [1] external, [0] transmit |
| pend_b | input | 4 | Channel B pending sources, same layout |
| iei | input | 1 | Chain enable from the higher-priority neighbour |
| ieo | output | 1 | Chain enable to the lower-priority neighbour |
| ack | input | 1 | Acknowledge cycle strobe, one cycle |
| rst_ius | input | 1 | Release the highest in-service bit |
| bus_out | output | 8 | Vector driven on the bus |
| bus_oe | output | 1 | Bus output enable |
| stat_vec | output | 8 | Status-modified vector, readable at any time |

## Verification
The assertions assume the following of the inputs:
- `ack` and `rst_ius` are one-cycle pulses and are never high in the same cycle.
- The control and base registers are not rewritten during an acknowledge.

The stimulus respects these limits by spacing each strobe with idle cycles between directed steps. Pending inputs change only between acknowledge pulses, so the vector seen during an acknowledge reflects a settled priority decision.

// File: rtl/intvec_ctl.sv
module intvec_ctl #(
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [4:0]    cfg_wdata,
  input  logic          base_we,
  input  logic [VW-1:0] base_wdata,
  input  logic [3:0]    pend_a,
  input  logic [3:0]    pend_b,
  input  logic          iei,
  output logic          ieo,
  input  logic          ack,
  input  logic          rst_ius,
  output logic [VW-1:0] bus_out,
  output logic          bus_oe,
  output logic [VW-1:0] stat_vec
);
  localparam int NS = 8;

  logic st_hi, mie, dlc, nv, vis;
  logic [VW-1:0] base;
  logic [NS-1:0] ius, ius_n;
  logic [NS-1:0] ip, ip_r, ius_r;
  logic pend_any, ius_any;
  logic [2:0] top_p, top_i, pend_code, ius_code;
  logic req, take;
  logic [VW-1:0] mod_vec;

  function automatic logic [2:0] code_of(input logic [2:0] r);
    logic [1:0] s;
    case (r[1:0])
      2'd0: s = 2'b01;
      2'd1: s = 2'b00;
      2'd2: s = 2'b10;
      default: s = 2'b11;
    endcase
    return {r[2], s};
  endfunction

  assign ip = {pend_a, pend_b};

  always_comb begin
    for (int r = 0; r < NS; r++) begin
      ip_r[r]  = ip[code_of(3'(r))];
      ius_r[r] = ius[code_of(3'(r))];
    end
  end

  always_comb begin
    pend_any = 1'b0;
    ius_any  = 1'b0;
    top_p    = '0;
    top_i    = '0;
    for (int r = 0; r < NS; r++) begin
      if (ip_r[r]) begin
        pend_any = 1'b1;
        top_p    = 3'(r);
      end
      if (ius_r[r]) begin
        ius_any = 1'b1;
        top_i   = 3'(r);
      end
    end
  end

  assign pend_code = code_of(top_p);
  assign ius_code  = code_of(top_i);
  assign req  = mie && pend_any && (!ius_any || (top_p > top_i));
  assign take = ack && iei && req;

  always_comb begin
    mod_vec = base;
    if (pend_any) begin
      if (st_hi) begin
        mod_vec[4] = pend_code[2];
        mod_vec[5] = pend_code[1];
        mod_vec[6] = pend_code[0];
      end else begin
        mod_vec[3:1] = pend_code;
      end
    end
  end

  assign stat_vec = mod_vec;
  assign bus_oe   = take && !nv;
  assign bus_out  = bus_oe ? (vis ? mod_vec : base) : '0;
  assign ieo      = iei && !dlc && !ius_any && !req;

  always_comb begin
    ius_n = ius;
    if (rst_ius && ius_any) ius_n[ius_code] = 1'b0;
    if (take) ius_n[pend_code] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {st_hi, mie, dlc, nv, vis} <= '0;
      base <= '0;
      ius  <= '0;
    end else begin
      if (cfg_we) {st_hi, mie, dlc, nv, vis} <= cfg_wdata;
      if (base_we) base <= base_wdata;
      ius <= ius_n;
    end
  end
endmodule

// File: rtl/intvec_ctl_chk.sv
module intvec_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ack,
  input logic       rst_ius,
  input logic       ieo,
  input logic       bus_oe,
  input logic       nv,
  input logic       dlc,
  input logic       mie,
  input logic [7:0] ius
);
  // R6
  vec_only_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> ack);

  // R6
  chain_blocked_after_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |=> !ieo);

  // R7
  suppress_holds_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nv |-> !bus_oe);

  // R8
  no_new_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mie |=> ($countones(ius) <= $countones($past(ius))));

  // R9
  chain_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dlc |-> !ieo);

  // R11
  release_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ius && !ack && ius != 8'h00) |=> ($countones(ius) + 1 == $countones($past(ius))));
endmodule

bind intvec_ctl intvec_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .rst_ius(rst_ius), .ieo(ieo),
  .bus_oe(bus_oe), .nv(nv), .dlc(dlc), .mie(mie), .ius(ius)
);

// File: tb/intvec_ctl_bench.sv
module intvec_ctl_bench;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, base_we = 0, iei = 1, ack = 0, rst_ius = 0;
  logic [4:0] cfg_wdata = '0;
  logic [7:0] base_wdata = '0;
  logic [3:0] pend_a = '0, pend_b = '0;
  logic ieo, bus_oe;
  logic [7:0] bus_out, stat_vec;
  int checks = 0, errors = 0;
  logic done = 0;

  localparam logic [4:0] HI = 5'b10000, ME = 5'b01000, CUT = 5'b00100,
                         NOV = 5'b00010, VIS = 5'b00001;

  localparam logic [24:0] TBL [24] = '{
    {1'b0,8'hA5,4'h0,4'h0,8'hA5}, {1'b0,8'hA5,4'h0,4'h1,8'hA1},
    {1'b0,8'hA5,4'h0,4'h2,8'hA3}, {1'b0,8'hA5,4'h0,4'h4,8'hA5},
    {1'b0,8'hA5,4'h0,4'h8,8'hA7}, {1'b0,8'hA5,4'h1,4'h0,8'hA9},
    {1'b0,8'hA5,4'h2,4'h0,8'hAB}, {1'b0,8'hA5,4'h4,4'h0,8'hAD},
    {1'b0,8'hA5,4'h8,4'h0,8'hAF}, {1'b0,8'hA5,4'h3,4'h0,8'hA9},
    {1'b0,8'hA5,4'h6,4'h0,8'hAD}, {1'b0,8'hA5,4'hC,4'h0,8'hAF},
    {1'b0,8'hA5,4'h2,4'h8,8'hAB}, {1'b0,8'hA5,4'h0,4'h3,8'hA1},
    {1'b0,8'hA5,4'h0,4'hF,8'hA7}, {1'b1,8'hA5,4'h0,4'h0,8'hA5},
    {1'b1,8'hA5,4'h0,4'h2,8'hC5}, {1'b1,8'hA5,4'h0,4'h4,8'hA5},
    {1'b1,8'hA5,4'h1,4'h0,8'h95}, {1'b1,8'hA5,4'h8,4'h0,8'hF5},
    {1'b1,8'hA5,4'h0,4'h8,8'hE5}, {1'b1,8'hA5,4'h2,4'h0,8'hD5},
    {1'b0,8'h00,4'h4,4'h0,8'h0C}, {1'b1,8'hFF,4'h0,4'h1,8'h8F}
  };

  intvec_ctl u_intvec_ctl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .base_we(base_we), .base_wdata(base_wdata), .pend_a(pend_a), .pend_b(pend_b),
    .iei(iei), .ieo(ieo), .ack(ack), .rst_ius(rst_ius),
    .bus_out(bus_out), .bus_oe(bus_oe), .stat_vec(stat_vec)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [4:0] v);
    cfg_wdata = v; cfg_we = 1; tick(); cfg_we = 0;
  endtask

  task automatic wr_base(input logic [7:0] v);
    base_wdata = v; base_we = 1; tick(); base_we = 0;
  endtask

  task automatic do_ack(output logic oe, output logic [7:0] vo);
    ack = 1; #1; oe = bus_oe; vo = bus_out; @(posedge clk); @(negedge clk); ack = 0; #1;
  endtask

  task automatic release_ius();
    rst_ius = 1; tick(); rst_ius = 0; #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic oe;
    logic [7:0] vo;
    repeat (3) tick();
    rst_n = 1; #1;
    // R1 reset state
    chk("R1 bus_oe", 8'(bus_oe), 8'h0);
    chk("R1 stat_vec", stat_vec, 8'h00);
    chk("R1 ieo", 8'(ieo), 8'(iei));

    // R2 R3 R4 R5 table walk
    for (int i = 0; i < 24; i++) begin
      wr_cfg(TBL[i][24] ? HI : 5'b0);
      wr_base(TBL[i][23:16]);
      pend_a = TBL[i][15:12]; pend_b = TBL[i][11:8];
      #1;
      chk($sformatf("R2/R3/R4/R5 row %0d", i), stat_vec, TBL[i][7:0]);
      chk("R8 ieo follows iei", 8'(ieo), 8'(iei));
    end
    pend_a = 0; pend_b = 0;

    // R8 master enable off: no request, ack takes nothing
    wr_cfg(VIS); wr_base(8'hA5);
    pend_a = 4'h4; #1;
    chk("R8 ieo with mie off", 8'(ieo), 8'h1);
    do_ack(oe, vo);
    chk("R8 no vector", 8'(oe), 8'h0);
    chk("R12 bus idle", vo, 8'h00);
    pend_a = 0; #1;
    chk("R8 no ius set", 8'(ieo), 8'h1);
    iei = 0; #1;
    chk("R8 ieo follows low iei", 8'(ieo), 8'h0);
    iei = 1;

    // R6 taken acknowledge with status
    wr_cfg(ME | VIS);
    pend_a = 4'h4; #1;
    chk("R6 request pulls ieo", 8'(ieo), 8'h0);
    do_ack(oe, vo);
    chk("R6 bus_oe", 8'(oe), 8'h1);
    chk("R6 vector with status", vo, 8'hAD);
    pend_a = 0; #1;
    chk("R6 ius holds ieo", 8'(ieo), 8'h0);
    release_ius();
    chk("R11 release", 8'(ieo), 8'h1);

    // R6 without status
    wr_cfg(ME);
    pend_a = 4'h4;
    do_ack(oe, vo);
    chk("R6 plain vector", vo, 8'hA5);
    pend_a = 0; release_ius();

    // R7 vector suppressed
    wr_cfg(ME | NOV | VIS);
    pend_a = 4'h4;
    do_ack(oe, vo);
    chk("R7 bus stays off", 8'(oe), 8'h0);
    chk("R12 bus zero", vo, 8'h00);
    pend_a = 0; #1;
    chk("R7 ius still set", 8'(ieo), 8'h0);
    release_ius();

    // R8 ius kept after mie cleared
    wr_cfg(ME | VIS);
    pend_b = 4'h1;
    do_ack(oe, vo);
    pend_b = 0;
    wr_cfg(VIS); #1;
    chk("R8 ius kept", 8'(ieo), 8'h0);
    release_ius();
    chk("R8 after release", 8'(ieo), 8'h1);

    // R9 chain cut
    wr_cfg(CUT); #1;
    chk("R9 ieo low", 8'(ieo), 8'h0);

    // R10 iei low
    wr_cfg(ME | VIS);
    iei = 0; pend_a = 4'h8;
    do_ack(oe, vo);
    chk("R10 no vector", 8'(oe), 8'h0);
    pend_a = 0; iei = 1; #1;
    chk("R10 no ius", 8'(ieo), 8'h1);

    // R11 nesting
    pend_b = 4'h1;
    do_ack(oe, vo);
    chk("R11 B tx vector", vo, 8'hA1);
    pend_a = 4'h8; #1;
    chk("R11 higher requests", 8'(ieo), 8'h0);
    do_ack(oe, vo);
    chk("R11 nested vector", vo, 8'hAF);
    pend_a = 0;
    do_ack(oe, vo);
    chk("R11 equal rank ignored", 8'(oe), 8'h0);
    release_ius();
    chk("R11 lower still in service", 8'(ieo), 8'h0);
    do_ack(oe, vo);
    chk("R11 still blocked", 8'(oe), 8'h0);
    pend_b = 0;
    release_ius();
    chk("R11 all released", 8'(ieo), 8'h1);

    // R1 reset clears configuration
    wr_cfg(5'b11111); wr_base(8'hFF);
    rst_n = 0; tick(); rst_n = 1;
    pend_a = 4'h8; #1;
    chk("R1 cfg cleared ieo", 8'(ieo), 8'h1);
    chk("R1 low mode base zero", stat_vec, 8'h0E);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule